// File: doc/BRIEF.md
# Dual-Lane Burst SPI Controller

This block is a full-duplex serial peripheral controller that can run as bus master or as bus slave. A host programs it through a small word-wide register window. The host writes the transmit words and a control word, then sets the go bit. The controller shifts the words out on one or two data lanes while it gathers the incoming bits. It then raises a completion flag and makes the received words readable.

As master, it generates the serial clock from one of two divider values and drives two active-low slave selects. It can stretch a transfer with idle gaps after every byte or only between words. As slave, it follows an external clock and select, which it resynchronises into its own clock domain. Two single-cycle request pulses let a DMA engine refill the transmit words and collect the received ones.

Register map (bus_addr):
- 0 = control
- 1 = dividers: divider 0 in [15:0], divider 1 in [31:16]
- 2 and 3 = transmit words A and B
- 4 and 5 = received words A and B, read-only
- 6 = status: [0] busy, [1] done

Control bits:
- [0] go, which reads back 0
- [1] master
- [2] LSB-first
- [3] dual lane
- [4] two-word burst
- [5] byte swap
- [6] clock polarity
- [7] gap after every byte
- [12:8] word length, where 0 means 32
- [19:16] gap length
- [20] divider select
- [22:21] slave-select enables

Top module: `spi_duo_ctrl`

## Requirements
- R1: After reset, status reads 0, both received words read 0, sclk_o is 0, ss_o is 2'b11 and mosi_o is 0.
- R2: A transfer has exactly L×W serial clock periods, where L is the word length from control [12:8] (1 to 31, with 0 meaning 32) and W is the number of words sent one after another. A received word is right-aligned in its register and the bits above L read as 0.
- R3: When control [2] is 0, bit L-1 of each word is sent and received first. When it is 1, bit 0 is first.
- R4: When control [4] is 1 in single-lane mode, word A and then word B are sent on lane 0 under one unbroken slave-select assertion. The received bits fill word A and then word B. With [4] at 0, received word B reads 0 after the transfer.
- R5: When control [3] is 1, word A is shifted on lane 0 and word B on lane 1 at the same time, for L clock periods. Lane 0 fills received word A and lane 1 fills received word B. In single-lane mode, mosi_o[1] stays 0.
- R6: In master mode, ss_o[i] is driven low for the whole transfer when control bit 21+i is 1. Otherwise it stays high, and both outputs are high when no master transfer is running.
- R7: When control [5] is 1, the four bytes of each transmit word are reversed in order (byte 0 swaps with byte 3, byte 1 with byte 2) before shifting. The received words read back with the same reversal.
- R8: A nonzero gap length G in control [19:16] holds SCLK at its idle level for G clock periods, with the slave select kept low. The gap falls after every 8th bit of a word when control [7] is 1, and at every word boundary. A gap length of 0 inserts no gap.
- R9: Each SCLK half period lasts D+1 system clocks. D is divider 0, or divider 1 when control [20] is 1.
- R10: SCLK idles at control [6]. Data changes on the trailing edge and is sampled on the leading edge, where the leading edge is the first edge away from idle.
- R11: The busy flag is set from the go write until the transfer ends, and done is set at the end. The received registers change only at the end. Writes to control or dividers while busy are ignored.
- R12: tx_dreq pulses for one cycle right after a transfer starts, once the transmit words have been copied. rx_dreq pulses for one cycle in the cycle that the received words are updated.
- R13: In slave mode, with ss_i low, the block samples slv_mosi_i on leading edges of sclk_i and drives slv_miso_o from the transmit words. It completes after the final bit has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| sclk_o | output | 1 | Serial clock in master mode |
| ss_o | output | 2 | Active-low slave selects in master mode |
| mosi_o | output | 2 | Master serial data out, lanes 1 and 0 |
| miso_i | input | 2 | Master serial data in, lanes 1 and 0 |
| sclk_i | input | 1 | Serial clock in slave mode |
| ss_i | input | 1 | Active-low select in slave mode |
| slv_mosi_i | input | 2 | Slave serial data in |
| slv_miso_o | output | 2 | Slave serial data out |
| tx_dreq | output | 1 | Transmit data request pulse |
| rx_dreq | output | 1 | Receive data ready pulse |

## Verification
The bound checker watches the idle state of the serial clock and selects on every cycle. It also checks that the received registers are never disturbed mid-transfer, that done and rx_dreq coincide exactly with the end of busy, and that tx_dreq is a single pulse at the start. Only the bench's scenarios can show the bit-level content: the bit order, byte swap, lane assignment and burst sequencing. The same goes for the exact period count under the dividers and gaps, and the slave-side exchange against an external clock.

// File: rtl/spi_duo_ctrl.sv
module spi_duo_ctrl #(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int GW   = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk_o,
  output logic [1:0]    ss_o,
  output logic [1:0]    mosi_o,
  input  logic [1:0]    miso_i,
  input  logic          sclk_i,
  input  logic          ss_i,
  input  logic [1:0]    slv_mosi_i,
  output logic [1:0]    slv_miso_o,
  output logic          tx_dreq,
  output logic          rx_dreq
);
  localparam int LW = $clog2(DW);
  localparam int NB = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP} st_t;

  function automatic logic [DW-1:0] bswap(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    for (int i = 0; i < NB; i++) r[8*i +: 8] = v[DW-8-8*i +: 8];
    return r;
  endfunction

  logic            master_q, lsb_q, dual_q, burst_q, reord_q, cpol_q, bgap_q, dsel_q;
  logic [LW-1:0]   wlen_q;
  logic [GW-1:0]   gap_q;
  logic [1:0]      ssen_q;
  logic [DIVW-1:0] div0_q, div1_q, hcnt;
  logic [DW-1:0]   tx0_q, tx1_q, sh0, sh1, acc0, acc1, acc0_n, acc1_n, rx0_q, rx1_q;
  logic            busy_q, done_q, wsel;
  logic [LW-1:0]   bcnt;
  logic [GW:0]     gcnt;
  st_t             st;
  logic [2:0]      sc_s;
  logic [1:0]      ssn_s;
  logic [1:0]      mo_s0, mo_s1;

  logic [LW:0]     wbits;
  logic [LW-1:0]   idx;
  logic            last_bit, last_word, tick, m_run, slv_act, lead, trail;
  logic            samp, edge_end, fin, adv, need_gap, wr_cfg, start;
  logic            tx_l0, tx_l1;
  logic [1:0]      in_b;
  logic [DIVW-1:0] dv;
  logic [DW-1:0]   ctrl_rd;

  assign wbits     = (wlen_q == '0) ? (LW+1)'(DW) : {1'b0, wlen_q};
  assign idx       = lsb_q ? bcnt : LW'(wbits - (LW+1)'(1) - {1'b0, bcnt});
  assign last_bit  = ({1'b0, bcnt} == wbits - (LW+1)'(1));
  assign last_word = dual_q | ~burst_q | wsel;
  assign dv        = dsel_q ? div1_q : div0_q;
  assign tick      = (hcnt == dv);
  assign m_run     = busy_q & master_q;
  assign slv_act   = busy_q & ~master_q & ~ssn_s[1];
  assign lead      = ((sc_s[1] ^ cpol_q) & ~(sc_s[2] ^ cpol_q));
  assign trail     = (~(sc_s[1] ^ cpol_q) & (sc_s[2] ^ cpol_q));
  assign edge_end  = m_run && (st == ST_HIGH) && tick;
  assign samp      = master_q ? (m_run && (st == ST_LOW) && tick) : (slv_act && lead);
  assign fin       = master_q ? (edge_end && last_bit && last_word)
                              : (samp && last_bit && last_word);
  assign adv       = master_q ? (edge_end && !fin) : (slv_act && trail);
  assign need_gap  = (gap_q != '0) && (last_bit || (bgap_q && (&bcnt[2:0])));
  assign in_b      = master_q ? miso_i : mo_s1;
  assign tx_l0     = (!dual_q && wsel) ? sh1[idx] : sh0[idx];
  assign tx_l1     = dual_q & sh1[idx];
  assign wr_cfg    = bus_we && (bus_addr == 3'd0) && !busy_q;
  assign start     = wr_cfg && bus_wdata[0];

  assign sclk_o     = cpol_q ^ (m_run && (st == ST_HIGH));
  assign ss_o       = m_run ? ~ssen_q : 2'b11;
  assign mosi_o     = m_run ? {tx_l1, tx_l0} : 2'b00;
  assign slv_miso_o = (busy_q && !master_q) ? {tx_l1, tx_l0} : 2'b00;

  always_comb begin
    acc0_n = acc0;
    acc1_n = acc1;
    if (samp) begin
      if (!dual_q && wsel) acc1_n[idx] = in_b[0];
      else                 acc0_n[idx] = in_b[0];
      if (dual_q)          acc1_n[idx] = in_b[1];
    end
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[1] = master_q;
    ctrl_rd[2] = lsb_q;
    ctrl_rd[3] = dual_q;
    ctrl_rd[4] = burst_q;
    ctrl_rd[5] = reord_q;
    ctrl_rd[6] = cpol_q;
    ctrl_rd[7] = bgap_q;
    ctrl_rd[8 +: LW] = wlen_q;
    ctrl_rd[16 +: GW] = gap_q;
    ctrl_rd[20] = dsel_q;
    ctrl_rd[22:21] = ssen_q;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = ctrl_rd;
      3'd1:    bus_rdata = DW'({div1_q, div0_q});
      3'd2:    bus_rdata = tx0_q;
      3'd3:    bus_rdata = tx1_q;
      3'd4:    bus_rdata = reord_q ? bswap(rx0_q) : rx0_q;
      3'd5:    bus_rdata = reord_q ? bswap(rx1_q) : rx1_q;
      3'd6:    bus_rdata = DW'({done_q, busy_q});
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_s  <= '0;
      ssn_s <= 2'b11;
      mo_s0 <= '0;
      mo_s1 <= '0;
    end else begin
      sc_s  <= {sc_s[1:0], sclk_i};
      ssn_s <= {ssn_s[0], ss_i};
      mo_s0 <= slv_mosi_i;
      mo_s1 <= mo_s0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {master_q, lsb_q, dual_q, burst_q, reord_q, cpol_q, bgap_q, dsel_q} <= '0;
      wlen_q <= '0; gap_q <= '0; ssen_q <= '0;
      div0_q <= '0; div1_q <= '0; hcnt <= '0; gcnt <= '0;
      tx0_q <= '0; tx1_q <= '0; sh0 <= '0; sh1 <= '0;
      acc0 <= '0; acc1 <= '0; rx0_q <= '0; rx1_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; wsel <= 1'b0; bcnt <= '0;
      st <= ST_IDLE; tx_dreq <= 1'b0; rx_dreq <= 1'b0;
    end else begin
      tx_dreq <= start;
      rx_dreq <= fin;
      if (wr_cfg) begin
        master_q <= bus_wdata[1];
        lsb_q    <= bus_wdata[2];
        dual_q   <= bus_wdata[3];
        burst_q  <= bus_wdata[4];
        reord_q  <= bus_wdata[5];
        cpol_q   <= bus_wdata[6];
        bgap_q   <= bus_wdata[7];
        wlen_q   <= bus_wdata[8 +: LW];
        gap_q    <= bus_wdata[16 +: GW];
        dsel_q   <= bus_wdata[20];
        ssen_q   <= bus_wdata[22:21];
      end
      if (bus_we && bus_addr == 3'd1 && !busy_q) begin
        div0_q <= bus_wdata[0 +: DIVW];
        div1_q <= bus_wdata[DIVW +: DIVW];
      end
      if (bus_we && bus_addr == 3'd2) tx0_q <= bus_wdata;
      if (bus_we && bus_addr == 3'd3) tx1_q <= bus_wdata;

      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        bcnt   <= '0;
        wsel   <= 1'b0;
        acc0   <= '0;
        acc1   <= '0;
        hcnt   <= '0;
        sh0    <= bus_wdata[5] ? bswap(tx0_q) : tx0_q;
        sh1    <= bus_wdata[5] ? bswap(tx1_q) : tx1_q;
        st     <= bus_wdata[1] ? ST_LOW : ST_IDLE;
      end else if (busy_q) begin
        acc0 <= acc0_n;
        acc1 <= acc1_n;
        if (m_run) hcnt <= tick ? '0 : hcnt + 1'b1;
        case (st)
          ST_LOW:  if (tick) st <= ST_HIGH;
          ST_HIGH: if (tick) begin
            if (fin) st <= ST_IDLE;
            else if (need_gap) begin
              st   <= ST_GAP;
              gcnt <= {gap_q, 1'b0} - 1'b1;
            end else st <= ST_LOW;
          end
          ST_GAP:  if (tick) begin
            if (gcnt == '0) st <= ST_LOW;
            else gcnt <= gcnt - 1'b1;
          end
          default: ;
        endcase
        if (adv) begin
          if (last_bit) begin
            bcnt <= '0;
            wsel <= 1'b1;
          end else bcnt <= bcnt + 1'b1;
        end
        if (fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx0_q  <= acc0_n;
          rx1_q  <= acc1_n;
        end
      end
    end
  end
endmodule

// File: rtl/spi_duo_ctrl_chk.sv
module spi_duo_ctrl_chk #(
  parameter int DW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          cpol,
  input logic          sclk_o,
  input logic [1:0]    ss_o,
  input logic          tx_dreq,
  input logic          rx_dreq,
  input logic [DW-1:0] rx0,
  input logic [DW-1:0] rx1
);
  assert_ss_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ss_o == 2'b11);

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o == cpol);

  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rx0) && $stable(rx1)));

  assert_done_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_rx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq |-> $fell(busy));

  assert_rx_pulse_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_dreq);

  assert_tx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |-> $rose(busy));

  assert_tx_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq |=> !tx_dreq);
endmodule

bind spi_duo_ctrl spi_duo_ctrl_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .done(done_q), .cpol(cpol_q),
  .sclk_o(sclk_o), .ss_o(ss_o), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
  .rx0(rx0_q), .rx1(rx1_q)
);

// File: tb/spi_duo_ctrl_tb_top.sv
module spi_duo_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd6;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk_o, tx_dreq, rx_dreq;
  logic [1:0] ss_o, mosi_o, miso_i, slv_miso_o;
  logic sclk_i = 1'b0, ss_i = 1'b1;
  logic [1:0] slv_mosi_i = 2'b00;

  int checks = 0, fails = 0;
  bit finished = 0;

  localparam logic [63:0] PAT0 = 64'hA5C3_1E96_7B2D_F048;
  localparam logic [63:0] PAT1 = 64'h3C69_D2B4_0F87_E15A;

  // ctrl, tx A, tx B, expected SCLK periods
  localparam int NV = 7;
  localparam logic [127:0] VEC [NV] = '{
    {32'h0020_0803, 32'h0000_00B7, 32'h0000_0000, 32'd8},
    {32'h0040_0007, 32'hDEAD_BEEF, 32'h0000_0000, 32'd32},
    {32'h0060_0C13, 32'h0000_0A5C, 32'h0000_03E1, 32'd24},
    {32'h0060_102F, 32'h1234_5678, 32'h9ABC_DEF0, 32'd16},
    {32'h0030_0553, 32'h0000_0016, 32'h0000_0009, 32'd10},
    {32'h0020_0103, 32'h0000_0001, 32'h0000_0000, 32'd1},
    {32'h0020_0023, 32'h0102_0304, 32'h0000_0000, 32'd32}
  };

  spi_duo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o), .ss_o(ss_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i), .ss_i(ss_i),
    .slv_mosi_i(slv_mosi_i), .slv_miso_o(slv_miso_o), .tx_dreq(tx_dreq),
    .rx_dreq(rx_dreq)
  );

  always #2.5 clk = ~clk;

  // external slave model for master-mode transfers
  logic [63:0] cap0 = '0, cap1 = '0;
  int ncap = 0, mpos = 0;
  logic m_cpol = 1'b0;
  assign miso_i = (mpos < 64) ? {PAT1[63-mpos], PAT0[63-mpos]} : 2'b00;
  always @(sclk_o) begin
    if (ss_o != 2'b11) begin
      if (sclk_o != m_cpol) begin
        cap0 = {cap0[62:0], mosi_o[0]};
        cap1 = {cap1[62:0], mosi_o[1]};
        ncap++;
      end else mpos++;
    end
  end

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [63:0] exp_tx(input logic [31:0] a, input logic [31:0] b,
                                         input int wl, input int nw, input bit lsb, input bit ro);
    logic [63:0] e = '0;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d = (w == 0) ? a : b;
      if (ro) d = bsw(d);
      for (int i = 0; i < wl; i++) e = {e[62:0], d[lsb ? i : wl-1-i]};
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [63:0] p, input int k0, input int wl,
                                         input bit lsb, input bit ro);
    logic [31:0] r = '0;
    for (int i = 0; i < wl; i++) r[lsb ? i : wl-1-i] = p[63-(k0+i)];
    return ro ? bsw(r) : r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd6;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_addr = 3'd6;
    #0.5;
  endtask

  task automatic model_reset(input logic cp);
    cap0 = '0; cap1 = '0; ncap = 0; mpos = 0; m_cpol = cp;
  endtask

  // waits for the end of a transfer started at the previous edge
  task automatic wait_end(input logic [1:0] ss_exp, output int cyc, output bit ss_ok,
                          output bit txp, output bit rxp);
    logic [31:0] s;
    cyc = 0; ss_ok = 1; txp = tx_dreq;
    rd(3'd6, s);
    while (s[0] && cyc < 5000) begin
      cyc++;
      if (ss_o != ss_exp) ss_ok = 0;
      @(negedge clk);
      rd(3'd6, s);
    end
    rxp = rx_dreq;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, rec, ctl;
    int cyc;
    bit ss_ok, txp, rxp;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd6, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 rx0", v, 0);
    chk(sclk_o == 0 && ss_o == 2'b11 && mosi_o == 0, "R1 pins", {sclk_o, ss_o, mosi_o}, 5'b01100);

    wr(3'd1, 32'h0002_0000); // divider0 = 0, divider1 = 2

    for (int n = 0; n < NV; n++) begin
      logic [31:0] c, a, b;
      int per, wl, nw, dvv;
      bit lsb, dual, burst, ro;
      {c, a, b, per} = {VEC[n][127:96], VEC[n][95:64], VEC[n][63:32], VEC[n][31:0]};
      lsb = c[2]; dual = c[3]; burst = c[4]; ro = c[5];
      wl = (c[12:8] == 0) ? 32 : int'(c[12:8]);
      nw = (burst && !dual) ? 2 : 1;
      dvv = c[20] ? 2 : 0;
      wr(3'd2, a); wr(3'd3, b);
      wr(3'd0, c & ~32'h1);
      model_reset(c[6]);
      @(negedge clk);
      wr(3'd0, c);
      wait_end(~c[22:21], cyc, ss_ok, txp, rxp);
      chk(ncap == per, "R2 period count", ncap, per);
      chk(cyc == 2*per*(dvv+1), "R9 half period length", cyc, 2*per*(dvv+1));
      chk(ss_ok, "R6/R4 select held", ss_ok, 1);
      chk(txp && rxp, "R12 dma pulses", {txp, rxp}, 2'b11);
      if (dual) begin
        chk(cap0 == exp_tx(a, a, wl, 1, lsb, ro), "R5 lane0 out", cap0, exp_tx(a, a, wl, 1, lsb, ro));
        chk(cap1 == exp_tx(b, b, wl, 1, lsb, ro), "R5 lane1 out", cap1, exp_tx(b, b, wl, 1, lsb, ro));
      end else begin
        chk(cap0 == exp_tx(a, b, wl, nw, lsb, ro), "R3/R4/R7 serial out", cap0, exp_tx(a, b, wl, nw, lsb, ro));
        chk(cap1 == 0, "R5 lane1 quiet", cap1, 0);
      end
      rd(3'd4, v);
      rec = exp_rx(PAT0, 0, wl, lsb, ro);
      chk(v == rec, "R2/R3/R7 rx word A", v, rec);
      rd(3'd5, v);
      rec = dual ? exp_rx(PAT1, 0, wl, lsb, ro) : (burst ? exp_rx(PAT0, wl, wl, lsb, ro) : 32'h0);
      chk(v == rec, "R4/R5 rx word B", v, rec);
      rd(3'd6, v);
      chk(v == 32'h2, "R11 done flag", v, 2);
    end

    // R8 byte gaps: 16 bits, gap 2, divider0
    wr(3'd0, 32'h0022_1082); model_reset(1'b0); @(negedge clk);
    wr(3'd0, 32'h0022_1083);
    wait_end(2'b10, cyc, ss_ok, txp, rxp);
    chk(cyc == 36, "R8 byte gap timing", cyc, 36);
    chk(ss_ok && ncap == 16, "R8 select held in gap", {ss_ok, ncap}, {1'b1, 32'd16});

    // R8 word gap: burst of 8-bit words, gap 3, divider1 = 2
    wr(3'd0, 32'h0033_0812); model_reset(1'b0); @(negedge clk);
    wr(3'd0, 32'h0033_0813);
    wait_end(2'b10, cyc, ss_ok, txp, rxp);
    chk(cyc == 114, "R8 word gap timing", cyc, 114);

    // R11 config writes ignored while busy, rx held
    wr(3'd0, 32'h0020_0802); model_reset(1'b0);
    rd(3'd4, rec);
    wr(3'd0, 32'h0020_0803);
    wr(3'd0, 32'h0020_0F03);
    wr(3'd1, 32'h0000_0005);
    rd(3'd4, v);
    chk(v == rec, "R11 rx stable while busy", v, rec);
    wait_end(2'b10, cyc, ss_ok, txp, rxp);
    chk(ncap == 8, "R11 ignored ctrl write", ncap, 8);
    rd(3'd0, ctl); chk(ctl == 32'h0020_0802, "R11 ctrl readback", ctl, 32'h0020_0802);
    rd(3'd1, v); chk(v == 32'h0002_0000, "R11 divider unchanged", v, 32'h0002_0000);

    // R13 slave mode, burst of two 8-bit words
    wr(3'd2, 32'h5A); wr(3'd3, 32'hC3);
    wr(3'd0, 32'h0000_0811);
    begin
      logic [15:0] seq = 16'h963E, got = '0;
      ss_i = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
        slv_mosi_i[0] = seq[15-k];
        repeat (8) @(negedge clk);
        sclk_i = 1'b1;
        got = {got[14:0], slv_miso_o[0]};
        repeat (8) @(negedge clk);
        sclk_i = 1'b0;
      end
      repeat (8) @(negedge clk);
      ss_i = 1'b1;
      chk(got == 16'h5AC3, "R13 slave out", got, 16'h5AC3);
      rd(3'd4, v); chk(v == 32'h96, "R13 slave rx A", v, 32'h96);
      rd(3'd5, v); chk(v == 32'h3E, "R13 slave rx B", v, 32'h3E);
      rd(3'd6, v); chk(v == 32'h2, "R13 slave done", v, 2);
      chk(ss_o == 2'b11 && sclk_o == 1'b0, "R6 master pins idle in slave", {ss_o, sclk_o}, 3'b110);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule